// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block expands one vector memory instruction into a series of per-element memory requests. A single start pulse captures the addressing mode, the base byte address, a signed stride, the load/store direction and the vector length VL. The block then produces VL requests, one per element. Each request carries a byte address, the element number and the direction, and it advances on a valid/ready handshake.

Three address patterns are supported. In contiguous mode the elements sit back to back. In strided mode the elements are spaced by a register-supplied element count. In indexed mode, which acts as a gather for loads and a scatter for stores, each element address is the base plus an offset taken from a stream of index elements. Elements are 8 bytes wide, so strides and offsets are counted in elements and scaled by 8. A one-cycle done pulse marks the end of the instruction. When VL is zero, done is raised without any request being issued.

Top module: `vagen_top`

## Requirements
- R1: With mode_i = 2'b00 (contiguous), or the spare code 2'b11 which behaves the same way, element i has address base + 8*i.
- R2: With mode_i = 2'b01 (strided), element i has address base + 8*i*stride. The stride is read as a two's-complement element count, so negative strides walk downward.
- R3: With mode_i = 2'b10 (indexed), element i has address base + 8*idx_i, where idx_i is the i-th index element taken from idx_data_i (two's complement). An index element is consumed only in the cycle when its request completes the handshake (idx_valid_i and idx_ready_o both high). idx_ready_o is low in every other mode and while the block is idle.
- R4: An instruction issues exactly VL requests (VL from 0 to 64), and req_elem_o counts 0, 1, …, VL-1 in order.
- R5: A request advances only when req_valid_o and req_ready_i are both high. While ready is low, req_addr_o, req_elem_o and req_store_o hold their values.
- R6: With VL = 0, done_o is high in the cycle after the start is accepted, and no request is issued.
- R7: done_o is a single-cycle pulse in the cycle after the final handshake. busy_o is high from the cycle after the start until the done cycle, and both are low after that.
- R8: A start pulse while busy_o is high is ignored. The running instruction continues unchanged, and no extra requests follow its done.
- R9: Address arithmetic wraps modulo 2^ADDR_W, with no fault.
- R10: req_store_o equals the store_i value captured at the accepted start, for every request of that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mode_i | input | 2 | Address mode: 00 contiguous, 01 strided, 10 indexed, 11 as 00 |
| store_i | input | 1 | 1 = store (scatter), 0 = load (gather) |
| base_i | input | ADDR_W | Base byte address |
| stride_i | input | ADDR_W | Signed stride, in elements |
| vl_i | input | CNT_W | Vector length, 0 to MAX_VL |
| idx_valid_i | input | 1 | Index element valid |
| idx_data_i | input | ADDR_W | Signed index element, in elements |
| idx_ready_o | output | 1 | Index element consumed |
| req_valid_o | output | 1 | Element request valid |
| req_ready_i | input | 1 | Memory accepts request |
| req_addr_o | output | ADDR_W | Element byte address |
| req_elem_o | output | ELEM_W | Element number |
| req_store_o | output | 1 | Request is a store |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Instruction complete, one-cycle pulse |

## Verification
For a nonzero VL, the first request is valid in the cycle after the start edge, and each later request is valid in the cycle after the previous handshake. done_o follows exactly one cycle after the final handshake. With VL = 0, done_o appears one cycle after the start edge.

The bench drives inputs just after the rising edge and samples on the falling edge. Each handshake it sees at a falling edge pops the next expected request from the scoreboard. The bench also records the cycle of that handshake, so that the done pulse can be checked against the cycle after it. A stalled request is compared with its value one falling edge later.

// File: rtl/vagen_pkg.sv
package vagen_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'b00,
    AM_STRIDE = 2'b01,
    AM_INDEX  = 2'b10,
    AM_RSVD   = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } sq_state_e;
endpackage

// File: rtl/vagen_seq.sv
module vagen_seq
  import vagen_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int CNT_W  = $clog2(MAX_VL + 1),
  parameter int ELEM_W = $clog2(MAX_VL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  vl_i,
  input  logic              fire_i,
  output logic              load_o,
  output logic              run_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [ELEM_W-1:0] elem_o
);
  sq_state_e         state_q, state_d;
  logic [CNT_W-1:0]  vl_q;
  logic [ELEM_W-1:0] elem_q;
  logic              last;

  assign load_o = start_i && (state_q == SQ_IDLE);
  assign run_o  = (state_q == SQ_RUN);
  assign done_o = (state_q == SQ_DONE);
  assign busy_o = (state_q != SQ_IDLE);
  assign elem_o = elem_q;
  assign last   = ({1'b0, elem_q} == vl_q - CNT_W'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (load_o) state_d = (vl_i == '0) ? SQ_DONE : SQ_RUN;
      SQ_RUN:  if (fire_i && last) state_d = SQ_DONE;
      SQ_DONE: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      vl_q    <= '0;
      elem_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        vl_q   <= vl_i;
        elem_q <= '0;
      end else if (fire_i && run_o && !last) begin
        elem_q <= elem_q + ELEM_W'(1);
      end
    end
  end

  p_elem_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> ({1'b0, elem_q} < vl_q));
  p_zero_vl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && vl_i == '0) |=> (done_o && !run_o));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(vl_q));
endmodule

// File: rtl/vagen_addr.sv
module vagen_addr
  import vagen_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ESZ_LOG2  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  amode_e            mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              fire_i,
  input  logic              use_idx_i,
  input  logic [ADDR_W-1:0] idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] UNIT_STEP = ADDR_W'(1) << ESZ_LOG2;

  logic [ADDR_W-1:0] base_q, cur_q, step_q, step_d, idx_off;

  // Step is fixed per instruction, so the running address needs only an adder.
  always_comb begin
    unique case (mode_i)
      AM_STRIDE: step_d = stride_i << ESZ_LOG2;
      default:   step_d = UNIT_STEP;
    endcase
  end

  assign idx_off = idx_i << ESZ_LOG2;
  assign addr_o  = use_idx_i ? (base_q + idx_off) : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
      step_q <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      cur_q  <= base_i;
      step_q <= step_d;
    end else if (fire_i) begin
      cur_q <= cur_q + step_q;
    end
  end

  p_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire_i && !load_i) |=> $stable(cur_q));
  p_base_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cur_q == $past(base_i)));
endmodule

// File: rtl/vagen_top.sv
module vagen_top
  import vagen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_VL   = 64,
  parameter int ESZ_LOG2 = 3,
  parameter int CNT_W    = $clog2(MAX_VL + 1),
  parameter int ELEM_W   = $clog2(MAX_VL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]  vl_i,
  input  logic              idx_valid_i,
  input  logic [ADDR_W-1:0] idx_data_i,
  output logic              idx_ready_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [ELEM_W-1:0] req_elem_o,
  output logic              req_store_o,
  output logic              busy_o,
  output logic              done_o
);
  amode_e mode_in;
  logic   idx_mode_q, store_q;
  logic   load, run, fire;

  assign mode_in = amode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_mode_q <= 1'b0;
      store_q    <= 1'b0;
    end else if (load) begin
      idx_mode_q <= (mode_in == AM_INDEX);
      store_q    <= store_i;
    end
  end

  // Indexed requests wait on the index stream; the index pops with the request.
  assign req_valid_o = run && (!idx_mode_q || idx_valid_i);
  assign fire        = req_valid_o && req_ready_i;
  assign idx_ready_o = run && idx_mode_q && req_ready_i;
  assign req_store_o = store_q;

  vagen_seq #(.MAX_VL(MAX_VL), .CNT_W(CNT_W), .ELEM_W(ELEM_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .vl_i   (vl_i),
    .fire_i (fire),
    .load_o (load),
    .run_o  (run),
    .done_o (done_o),
    .busy_o (busy_o),
    .elem_o (req_elem_o)
  );

  vagen_addr #(.ADDR_W(ADDR_W), .ESZ_LOG2(ESZ_LOG2)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .mode_i   (mode_in),
    .base_i   (base_i),
    .stride_i (stride_i),
    .fire_i   (fire),
    .use_idx_i(idx_mode_q),
    .idx_i    (idx_data_i),
    .addr_o   (req_addr_o)
  );

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !idx_mode_q) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_elem_o) && $stable(req_store_o)));
  p_idx_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_valid_i && idx_ready_o) |-> fire);
  p_idx_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !idx_ready_o);
  p_store_const_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && $past(req_valid_o)) |-> $stable(req_store_o));
endmodule

// File: tb/vagen_top_test.sv
module vagen_top_test;
  localparam int AW = 32;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, store_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [AW-1:0] base_i = '0, stride_i = '0, idx_data_i = '0;
  logic [6:0]  vl_i = '0;
  logic        idx_valid_i = 1'b0, req_ready_i = 1'b1;
  logic        idx_ready_o, req_valid_o, req_store_o, busy_o, done_o;
  logic [AW-1:0] req_addr_o;
  logic [5:0]  req_elem_o;

  int checks = 0, errors = 0, cyc = 0, last_fire = 0, rdy_mode = 0;
  logic [AW-1:0] ex_addr[$], iq[$];
  int            ex_elem[$];
  logic          ex_st[$];
  string         tag = "R1";

  vagen_top uut (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor and index/ready driver
  initial begin
    bit fire, ifire, pend;
    logic [AW-1:0] h_addr; logic [5:0] h_elem; logic h_st;
    pend = 0;
    forever begin
      @(negedge clk_i);
      if (pend && req_valid_o) begin
        chk(req_addr_o == h_addr, "R5", req_addr_o, h_addr);
        chk(req_elem_o == h_elem && req_store_o == h_st, "R5", req_elem_o, h_elem);
      end
      pend = 0;
      fire  = req_valid_o && req_ready_i;
      ifire = idx_valid_i && idx_ready_o;
      if (req_valid_o && !req_ready_i) begin
        pend = 1; h_addr = req_addr_o; h_elem = req_elem_o; h_st = req_store_o;
      end
      if (fire) begin
        last_fire = cyc;
        if (ex_addr.size() == 0) chk(0, "R4", req_elem_o, 0);
        else begin
          logic [AW-1:0] ea; int ee; logic es;
          ea = ex_addr.pop_front(); ee = ex_elem.pop_front(); es = ex_st.pop_front();
          chk(req_addr_o == ea, tag, req_addr_o, ea);
          chk(req_elem_o == 6'(ee), "R4", req_elem_o, ee);
          chk(req_store_o == es, "R10", req_store_o, es);
        end
      end
      @(posedge clk_i); #1;
      if (ifire && iq.size() > 0) void'(iq.pop_front());
      idx_valid_i = iq.size() > 0;
      idx_data_i  = (iq.size() > 0) ? iq[0] : '0;
      req_ready_i = (rdy_mode == 0) ? 1'b1 : (((cyc * 7) % 5) > 1);
    end
  end

  task automatic run_vec(input logic [1:0] m, input logic st, input logic [AW-1:0] b,
                         input logic [AW-1:0] s, input int vl, input string rq, input bit poke);
    int t;
    tag = rq;
    for (int i = 0; i < vl; i++) begin
      logic [AW-1:0] a, ix;
      ix = AW'((i * 37) % 23) - AW'(9);
      if (m == 2'b10) begin a = b + (ix << 3); iq.push_back(ix); end
      else if (m == 2'b01) a = b + ((s * AW'(i)) << 3);
      else a = b + AW'(8 * i);
      ex_addr.push_back(a); ex_elem.push_back(i); ex_st.push_back(st);
    end
    @(posedge clk_i); #1;
    mode_i = m; store_i = st; base_i = b; stride_i = s; vl_i = 7'(vl); start_i = 1'b1;
    @(posedge clk_i); #1; start_i = 1'b0;
    @(negedge clk_i);
    if (vl == 0) chk(done_o && !req_valid_o, "R6", {done_o, req_valid_o}, 2'b10);
    else chk(busy_o && !done_o, "R7", {busy_o, done_o}, 2'b10);
    t = 0;
    while (!done_o && t < 5000) begin
      @(negedge clk_i); t++;
      if (poke && t == 3) begin
        chk(busy_o, "R8", busy_o, 1);
        start_i = 1'b1; mode_i = 2'b01; base_i = 32'h5555_0000; stride_i = 32'd3; vl_i = 7'd2;
      end
      if (poke && t == 4) start_i = 1'b0;
    end
    chk(done_o, "R7", done_o, 1);
    chk(ex_addr.size() == 0, "R4", ex_addr.size(), 0);
    if (vl > 0) chk(cyc == last_fire + 1, "R7", cyc, last_fire + 1);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R7", {done_o, busy_o}, 0);
    if (poke) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk_i);
        chk(!req_valid_o && !busy_o, "R8", {req_valid_o, busy_o}, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!req_valid_o && !done_o && !busy_o && !idx_ready_o, "R7",
        {req_valid_o, done_o, busy_o, idx_ready_o}, 0);
    rst_ni = 1'b1;
    run_vec(2'b00, 1'b0, 32'h0000_1000, '0, 5, "R1", 0);
    run_vec(2'b11, 1'b1, 32'h0000_2000, 32'd99, 3, "R1", 0);
    run_vec(2'b01, 1'b0, 32'h0001_0000, 32'd4, 64, "R2", 0);
    run_vec(2'b01, 1'b1, 32'h0002_0000, -32'sd3, 7, "R2", 0);
    run_vec(2'b10, 1'b0, 32'h0003_0000, '0, 12, "R3", 0);
    run_vec(2'b00, 1'b0, 32'h0, '0, 0, "R6", 0);
    run_vec(2'b00, 1'b1, 32'hFFFF_FFF0, '0, 4, "R9", 0);
    rdy_mode = 1;
    run_vec(2'b01, 1'b0, 32'h0004_0000, 32'd2, 9, "R5", 0);
    run_vec(2'b10, 1'b1, 32'h0000_0040, '0, 10, "R3", 0);
    run_vec(2'b01, 1'b0, 32'h0000_0010, -32'sd1, 6, "R9", 0);
    rdy_mode = 0;
    run_vec(2'b00, 1'b0, 32'h0006_0000, '0, 10, "R8", 1);
    @(negedge clk_i);
    chk(!idx_ready_o, "R3", idx_ready_o, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule